// File: doc/BRIEF.md
# Class-Based Bus Arbiter with Chained Grants

This block allocates one shared system bus among a set of bus masters. The masters are sorted into request classes. Each class has one request line, which is the OR of its members' requests, and one grant line, which the arbiter drives. Inside a class the grant passes from master to master along a chain: a master that is not asking for the bus hands the grant to its neighbour, and the first one that is asking keeps it. Between classes the arbiter picks a winner by one of two policies, chosen by a mode input. The first is a fixed ranking, in which the highest-numbered class wins. The second is a round-robin, in which the class most recently granted drops to the bottom.

The bus owner signals that it holds the bus by raising a busy line. It frees the bus by lowering that line when its transaction completes. The arbiter makes no new decision while busy is high. In fixed-ranking mode a request from a class ranked above the owner asserts an active-low bus-clear output. That output tells the owner to finish and let go, and it stays asserted until the bus changes hands.

Top module: `class_bus_arbiter`

## Requirements
- R1: Reset state.
  - After reset no class or master grant is active and `bus_clr_no` is high.
  - The round-robin pointer starts at the top class, so the first rotating decision searches from class 0 upward.
- R2: When `rotate_mode_i` is 0 (fixed ranking), the requesting class with the highest index wins.
- R3: When `rotate_mode_i` is 1 (round-robin), the search starts one class above the most recently granted class and wraps around. The pointer takes the winner's index on every grant, in either mode.
- R4: Within a class, master 0 sits nearest the arbiter. The class grant reaches the lowest-indexed requesting master of that class, and no other master is granted. Master `k` of class `c` is bit `c*N_MST+k` of `mst_req_i` and `mst_gnt_o`.
- R5: Class grants are registered, one-hot or zero. A decision taken at a clock edge shows on `cls_gnt_o` right after that edge.
- R6: While `bus_busy_i` is high at a clock edge, the class grant does not change.
- R7: Transaction-based release and hand-over.
  - Once the owner has been seen busy, the first edge with `bus_busy_i` low releases the bus.
  - At that same edge the next winner is granted, or all grants drop if nothing is requested.
- R8: If the granted class withdraws its request before busy has been seen, the grant is cancelled and re-decided at the next edge with `bus_busy_i` low.
- R9: In fixed mode, a request from a class above the owner's class drives `bus_clr_no` low at the next edge. It stays low until the release edge and goes high at the edge that issues the next grant.
- R10: In round-robin mode, requests from other classes never drive `bus_clr_no` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rotate_mode_i | input | 1 | 0 = fixed ranking, 1 = round-robin between classes |
| mst_req_i | input | N_CLS*N_MST | Per-master bus requests, class-major |
| bus_busy_i | input | 1 | Bus held by the current owner |
| cls_gnt_o | output | N_CLS | Registered class grant lines |
| mst_gnt_o | output | N_CLS*N_MST | Grant as seen by each master after the chain |
| bus_clr_no | output | 1 | Active-low request for the owner to release the bus |

## Verification
The bench builds the arbiter with four classes of three masters each. The three-deep chains expose pass-through past idle masters and selection of the first requester. Four classes let the round-robin pointer wrap from class 3 back to class 0. They also give preemption enough headroom to occur from class 2 up to class 3. A long pseudo-random phase toggles the mode while a bench-side owner holds and releases the bus. This reaches preemption during held transactions, cancelled grants and back-to-back hand-overs.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_ROTATE = 1'b1
  } alloc_mode_e;
endpackage

// File: rtl/arb_class_pick.sv
`timescale 1ns/1ps
module arb_class_pick
  import arb_pkg::*;
#(
  parameter int N_CLS = 4,
  localparam int IDX_W = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
  input  logic [N_CLS-1:0] req_i,
  input  alloc_mode_e      mode_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             any_o,
  output logic [IDX_W-1:0] win_o
);
  always_comb begin
    int idx;
    idx   = 0;
    any_o = 1'b0;
    win_o = '0;
    if (mode_i == MODE_FIXED) begin
      for (int c = 0; c < N_CLS; c++) begin
        if (req_i[c]) begin
          win_o = IDX_W'(c);
          any_o = 1'b1;
        end
      end
    end else begin
      for (int i = 1; i <= N_CLS; i++) begin
        idx = (int'(last_i) + i) % N_CLS;
        if (!any_o && req_i[idx]) begin
          win_o = IDX_W'(idx);
          any_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arb_chain.sv
`timescale 1ns/1ps
module arb_chain #(
  parameter int N_MST = 3
) (
  input  logic             gnt_i,
  input  logic [N_MST-1:0] req_i,
  output logic [N_MST-1:0] gnt_o,
  output logic             any_o
);
  logic [N_MST-1:0] tok;

  assign tok[0] = gnt_i;
  for (genvar k = 1; k < N_MST; k++) begin : g_cell
    // idle master hands the grant on
    assign tok[k] = tok[k-1] & ~req_i[k-1];
  end

  assign gnt_o = tok & req_i;
  assign any_o = |req_i;
endmodule

// File: rtl/class_bus_arbiter.sv
`timescale 1ns/1ps
module class_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_CLS = 4,
  parameter int N_MST = 3,
  localparam int IDX_W = (N_CLS > 1) ? $clog2(N_CLS) : 1,
  localparam int TOT   = N_CLS * N_MST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rotate_mode_i,
  input  logic [TOT-1:0]   mst_req_i,
  input  logic             bus_busy_i,
  output logic [N_CLS-1:0] cls_gnt_o,
  output logic [TOT-1:0]   mst_gnt_o,
  output logic             bus_clr_no
);
  alloc_mode_e      mode;
  logic [N_CLS-1:0] cls_req;
  logic [N_CLS-1:0] gnt_q;
  logic             owned_q, taken_q, clr_q;
  logic [IDX_W-1:0] owner_q, last_q;
  logic             pick_any;
  logic [IDX_W-1:0] pick_win;
  logic             higher_req;
  logic             free;

  assign mode = alloc_mode_e'(rotate_mode_i);

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    arb_chain #(.N_MST(N_MST)) u_chain (
      .gnt_i (gnt_q[c]),
      .req_i (mst_req_i[c*N_MST +: N_MST]),
      .gnt_o (mst_gnt_o[c*N_MST +: N_MST]),
      .any_o (cls_req[c])
    );
  end

  arb_class_pick #(.N_CLS(N_CLS)) u_pick (
    .req_i  (cls_req),
    .mode_i (mode),
    .last_i (last_q),
    .any_o  (pick_any),
    .win_o  (pick_win)
  );

  always_comb begin
    higher_req = 1'b0;
    for (int c = 0; c < N_CLS; c++) begin
      if (c > int'(owner_q) && cls_req[c]) higher_req = 1'b1;
    end
  end

  // bus free: owner finished, or grant never taken and withdrawn
  assign free = !bus_busy_i && (!owned_q || taken_q || !cls_req[owner_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q   <= '0;
      owned_q <= 1'b0;
      taken_q <= 1'b0;
      clr_q   <= 1'b0;
      owner_q <= '0;
      last_q  <= IDX_W'(N_CLS - 1);
    end else if (free) begin
      clr_q   <= 1'b0;
      taken_q <= 1'b0;
      owned_q <= pick_any;
      if (pick_any) begin
        gnt_q   <= N_CLS'(1) << pick_win;
        owner_q <= pick_win;
        last_q  <= pick_win;
      end else begin
        gnt_q <= '0;
      end
    end else begin
      taken_q <= taken_q | (owned_q & bus_busy_i);
      clr_q   <= clr_q | (owned_q & (mode == MODE_FIXED) & higher_req);
    end
  end

  assign cls_gnt_o  = gnt_q;
  assign bus_clr_no = ~clr_q;

  assert_onehot_cls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cls_gnt_o));

  assert_onehot_mst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mst_gnt_o));

  assert_chain_delivers_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(cls_gnt_o & cls_req)) |-> (|mst_gnt_o));

  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_i |=> $stable(cls_gnt_o));

  assert_clr_fixed_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_clr_no) |-> !$past(rotate_mode_i));

  assert_clr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_clr_no && bus_busy_i) |=> !bus_clr_no);

  assert_clr_needs_owner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_clr_no |-> (|cls_gnt_o));
endmodule

// File: tb/class_bus_arbiter_tb.sv
`timescale 1ns/1ps
module class_bus_arbiter_tb;
  localparam int NC  = 4;
  localparam int NM  = 3;
  localparam int TOT = NC * NM;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           mode = 1'b0;
  logic [TOT-1:0] req = '0;
  logic           busy = 1'b0;
  logic [NC-1:0]  cls_gnt;
  logic [TOT-1:0] mst_gnt;
  logic           clr_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  class_bus_arbiter #(.N_CLS(NC), .N_MST(NM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rotate_mode_i(mode), .mst_req_i(req),
    .bus_busy_i(busy), .cls_gnt_o(cls_gnt), .mst_gnt_o(mst_gnt), .bus_clr_no(clr_n)
  );

  // behavioural reference
  int m_owned, m_taken, m_owner, m_last, m_clr;
  initial begin m_owned = 0; m_taken = 0; m_owner = 0; m_last = NC-1; m_clr = 0; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owned = 0; m_taken = 0; m_owner = 0; m_last = NC-1; m_clr = 0;
    end else begin
      bit cr[NC];
      bit fr;
      int win;
      for (int c = 0; c < NC; c++) begin
        cr[c] = 0;
        for (int k = 0; k < NM; k++) if (req[c*NM+k]) cr[c] = 1;
      end
      fr = !busy && (m_owned == 0 || m_taken == 1 || !cr[m_owner]);
      if (fr) begin
        win = -1;
        if (!mode) begin
          for (int c = 0; c < NC; c++) if (cr[c]) win = c;
        end else begin
          for (int i = 1; i <= NC; i++) if (win < 0 && cr[(m_last+i)%NC]) win = (m_last+i)%NC;
        end
        m_clr = 0; m_taken = 0;
        if (win >= 0) begin m_owned = 1; m_owner = win; m_last = win; end
        else m_owned = 0;
      end else begin
        if (m_owned == 1 && busy) m_taken = 1;
        if (m_owned == 1 && !mode)
          for (int c = 0; c < NC; c++) if (c > m_owner && cr[c]) m_clr = 1;
      end
    end
  end

  function automatic logic [NC-1:0] exp_cls();
    return (m_owned == 1) ? NC'(1) << m_owner : '0;
  endfunction

  function automatic logic [TOT-1:0] exp_mst();
    logic [TOT-1:0] r;
    r = '0;
    if (m_owned == 1) begin
      for (int k = NM-1; k >= 0; k--) if (req[m_owner*NM+k]) r = TOT'(1) << (m_owner*NM+k);
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [TOT-1:0] act, logic [TOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 class grant", TOT'(cls_gnt), TOT'(exp_cls()));
      chk("R4 master grant", mst_gnt, exp_mst());
      chk("R9 bus clear", TOT'(clr_n), TOT'(m_clr == 0));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  function automatic logic [TOT-1:0] bits(int a, int b = -1, int c = -1, int d = -1);
    logic [TOT-1:0] r;
    r = '0;
    if (a >= 0) r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    if (d >= 0) r[d] = 1'b1;
    return r;
  endfunction

  int unsigned lfsr = 32'h1ACE5EED;
  function automatic int unsigned rnd();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return lfsr;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hold, own;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R1 reset class grant", TOT'(cls_gnt), '0);
    chk("R1 reset master grant", mst_gnt, '0);
    chk("R1 reset clear high", TOT'(clr_n), TOT'(1));

    // R1: pointer at top class, so rotating picks class 0 over class 3
    mode = 1; req = bits(0, 9); step();
    chk("R1 first rotating pick", TOT'(cls_gnt), TOT'(4'b0001));
    req = '0; step();
    chk("R8 withdrawn grant drops", TOT'(cls_gnt), '0);

    // R2 fixed ranking, R4 chain picks lowest requesting master
    mode = 0; req = bits(5, 7, 10, 11); step();
    chk("R2 highest class wins", TOT'(cls_gnt), TOT'(4'b1000));
    chk("R4 first requester in chain", mst_gnt, bits(10));

    busy = 1; step();
    req = bits(0, 5, 7, 10) | bits(11); step();
    chk("R6 grant stable while busy", TOT'(cls_gnt), TOT'(4'b1000));
    chk("R9 no clear from lower class", TOT'(clr_n), TOT'(1));

    busy = 0; req = bits(0, 5, 7); step();
    chk("R7 hand-over at release edge", TOT'(cls_gnt), TOT'(4'b0100));
    chk("R4 grant passes idle master", mst_gnt, bits(7));

    // R9 preemption
    busy = 1; req = bits(0, 5, 7, 9); step();
    chk("R9 clear asserted", TOT'(clr_n), TOT'(0));
    step(); step();
    chk("R9 clear held while busy", TOT'(clr_n), TOT'(0));
    chk("R6 owner kept while busy", TOT'(cls_gnt), TOT'(4'b0100));
    busy = 0; step();
    chk("R9 clear removed on new grant", TOT'(clr_n), TOT'(1));
    chk("R9 higher class granted", TOT'(cls_gnt), TOT'(4'b1000));

    // R8 grant cancelled before busy
    req = bits(5, 7); step();
    chk("R8 re-decided after withdraw", TOT'(cls_gnt), TOT'(4'b0100));

    // R3 round-robin, R10 no clear
    mode = 1; req = '0; step();
    chk("R7 grants drop when idle", TOT'(cls_gnt), '0);
    req = bits(0, 3, 9); step();
    chk("R3 search starts above last", TOT'(cls_gnt), TOT'(4'b1000));
    busy = 1; step();
    busy = 0; step();
    chk("R3 wrap to class 0", TOT'(cls_gnt), TOT'(4'b0001));
    busy = 1; step();
    chk("R10 no clear in rotating", TOT'(clr_n), TOT'(1));
    busy = 0; step();
    chk("R3 next class 1", TOT'(cls_gnt), TOT'(4'b0010));
    busy = 0; req = '0; step();

    // pseudo-random traffic with a bench-side owner
    hold = 0; own = 0;
    for (int n = 0; n < 4000; n++) begin
      if (n % 300 == 0) mode = ~mode;
      if (hold > 0) begin
        if (!clr_n && hold > 1) hold = 1;
        hold--;
        if (hold == 0) begin busy = 0; req[own] = 1'b0; end
      end else if (!busy && mst_gnt != '0 && (rnd() % 4 != 0)) begin
        for (int i = 0; i < TOT; i++) if (mst_gnt[i]) own = i;
        busy = 1; hold = 1 + int'(rnd() % 5);
      end
      for (int i = 0; i < TOT; i++) begin
        if (rnd() % 16 == 0) req[i] = 1'b1;
        else if (!busy && rnd() % 32 == 0) req[i] = 1'b0;
      end
      step();
    end
    busy = 0; req = '0; step(); step();
    finish_run();
  end
endmodule